// File: doc/BRIEF.md
# Serial NOR Flash Device Emulator

This block plays the device side of a small serial NOR flash. A host reaches it over a four-wire SPI slave link: active-low select, serial clock, data in and data out. It runs in SPI mode 0 and sends the most significant bit first. The link is sampled with the fabric clock, so the block behaves like a real flash toward an SPI master running in the same design. One-byte opcodes select the action. The block handles write enable, status read, data read, page program, sector erase, bulk erase, sleep and wake. Memory contents live in an inferred byte RAM whose depth is a parameter. The 256-byte page is kept at every depth.

Programming can only clear bits. A write-enable latch must be set before any modify operation. After a program or erase starts, an internal cycle runs. A busy flag in the status byte shows that cycle, and the host polls it. The cycle walks the RAM and also waits out a minimum cycle count, so it stands in for the real program and erase time. A sleep state shuts out every instruction except the wake opcode.

Top module: `spi_flash_emu`

## Requirements
- R1: After reset the status byte reads 00h and the data output is low while the device is deselected.
- R2: Opcode 05h returns the status byte on every following byte of the same frame. Bit 0 is busy, bit 1 is the write-enable latch, and bits 7..2 are zero. Data is sampled on rising SCK and shifted out on falling SCK, MSB first.
- R3: Opcode 06h sent as a one-byte frame sets the write-enable latch.
- R4: Opcode 02h has the form opcode, three address bytes (MSB first), then data bytes. Each data byte is ANDed into the stored byte. Successive bytes go to successive addresses and wrap inside the addressed 256-byte page, so no byte spills into the next page.
- R5: Opcode D8h followed by three address bytes sets every byte of the aligned sector that holds the address to FFh. Other sectors are unchanged.
- R6: Opcode C7h sent as a one-byte frame sets every byte of the array to FFh.
- R7: Program and erase frames are ignored when the write-enable latch is clear.
- R8: The busy bit reads 1 from the select rise that starts a program or erase until both the RAM walk and the minimum cycle count are done. The busy bit and the write-enable latch then clear together.
- R9: While busy, every opcode except 05h is ignored, and a data read returns 00h.
- R10: Opcode B9h enters sleep. In sleep every instruction other than ABh is ignored and the output stays low. ABh leaves sleep.
- R11: Control opcodes (06h, B9h, ABh), program and erase act only when select rises on a byte boundary and the frame has the exact length: one byte for 06h, B9h and C7h, four bytes for D8h, and at least five bytes for 02h. Any other frame is dropped.
- R12: Opcode 03h followed by three address bytes streams bytes from successive addresses and wraps at the end of the array. Address bits above the array size are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock; samples the SPI lines |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | SPI select, active low |
| sck | input | 1 | SPI serial clock (mode 0) |
| mosi | input | 1 | SPI data from host |
| miso | output | 1 | SPI data to host, registered |

## Verification
The hardest case to reach from the ports is an instruction that lands while an internal cycle is still running. The bench uses the erase cycle lengths to fit that window. It sends a read or a sleep opcode just after an erase starts, well before the minimum cycle count can run out. It then proves the instruction was ignored: the read returns 00h instead of stored data, and a later write enable still shows up in the status byte. Frames that break off partway through a byte, and frames that carry one byte too many, are built with a bit-level driver to cover the framing rule.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_RDSR   = 8'h05;
  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_PROG   = 8'h02;
  localparam logic [7:0] OP_SERASE = 8'hD8;
  localparam logic [7:0] OP_BERASE = 8'hC7;
  localparam logic [7:0] OP_SLEEP  = 8'hB9;
  localparam logic [7:0] OP_WAKE   = 8'hAB;

  typedef enum logic [1:0] {
    JOB_NONE   = 2'd0,
    JOB_PROG   = 2'd1,
    JOB_SERASE = 2'd2,
    JOB_BERASE = 2'd3
  } job_e;
endpackage

// File: rtl/sfe_spi_port.sv
module sfe_spi_port #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       mosi,
  input  logic [7:0] tx_byte,
  output logic       cs_rise,
  output logic       on_boundary,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic [2:0] byte_cnt,
  output logic       miso
);
  localparam logic [2:0] CNT_SAT = 3'd5;

  logic [SYNC_STAGES-1:0] cs_sync, sck_sync, mosi_sync;
  logic cs_s, sck_s, mosi_s, cs_d, sck_d, sel;
  logic sck_rise, sck_fall;
  logic [2:0] bit_cnt;
  logic [6:0] shreg;
  logic [6:0] tx_sr;
  logic       load_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_sync   <= '1;
      sck_sync  <= '0;
      mosi_sync <= '0;
      cs_d      <= 1'b1;
      sck_d     <= 1'b0;
    end else begin
      cs_sync   <= {cs_sync[SYNC_STAGES-2:0], cs_n};
      sck_sync  <= {sck_sync[SYNC_STAGES-2:0], sck};
      mosi_sync <= {mosi_sync[SYNC_STAGES-2:0], mosi};
      cs_d      <= cs_s;
      sck_d     <= sck_s;
    end
  end

  assign cs_s     = cs_sync[SYNC_STAGES-1];
  assign sck_s    = sck_sync[SYNC_STAGES-1];
  assign mosi_s   = mosi_sync[SYNC_STAGES-1];
  assign sel      = !cs_s;
  assign sck_rise = sel && sck_s && !sck_d;
  assign sck_fall = sel && !sck_s && sck_d;
  assign cs_rise  = cs_s && !cs_d;
  assign on_boundary = (bit_cnt == 3'd0);

  // receive path
  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt   <= '0;
      byte_cnt  <= '0;
      shreg     <= '0;
      rx_byte   <= '0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (!sel) begin
        bit_cnt  <= '0;
        byte_cnt <= '0;
      end else if (sck_rise) begin
        shreg   <= {shreg[5:0], mosi_s};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          rx_byte   <= {shreg, mosi_s};
          byte_done <= 1'b1;
          if (byte_cnt != CNT_SAT) byte_cnt <= byte_cnt + 3'd1;
        end
      end
    end
  end

  // transmit path: next byte is taken on the first falling edge after a byte ends
  always_ff @(posedge clk) begin
    if (rst) begin
      miso      <= 1'b0;
      tx_sr     <= '0;
      load_pend <= 1'b0;
    end else if (!sel) begin
      miso      <= 1'b0;
      load_pend <= 1'b0;
    end else if (sck_fall) begin
      load_pend <= 1'b0;
      if (load_pend) {miso, tx_sr} <= tx_byte;
      else           {miso, tx_sr} <= {tx_sr, 1'b0};
    end else if (byte_done) begin
      load_pend <= 1'b1;
    end
  end

  AST_BYTE_PULSE: assert property (@(posedge clk) disable iff (rst)
    byte_done |=> !byte_done); // R11
endmodule

// File: rtl/sfe_array_engine.sv
module sfe_array_engine
  import sfe_pkg::*;
#(
  parameter int MEM_BYTES    = 2048,
  parameter int SECTOR_BYTES = 1024,
  parameter int PAGE_BYTES   = 256,
  localparam int AW = $clog2(MEM_BYTES),
  localparam int PW = $clog2(PAGE_BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  job_e          job,
  input  logic [AW-1:0] base,
  output logic          active,
  input  logic          buf_clr,
  input  logic          buf_we,
  input  logic [PW-1:0] buf_addr,
  input  logic [7:0]    buf_wdata,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  logic [7:0] mem [MEM_BYTES];
  logic [7:0] pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pvalid;

  job_e          job_q;
  logic [AW-1:0] base_q, idx, limit;
  logic          phase;
  logic [AW-1:0] mem_addr;
  logic          mem_we;
  logic [7:0]    mem_wd, mem_q, pb_q;
  logic          pv_q;

  initial begin
    for (int i = 0; i < MEM_BYTES; i++) mem[i] = 8'hFF;
  end

  // single-port array: walker owns it while active, read path otherwise
  assign mem_addr = active ? (base_q + idx) : rd_addr;
  assign mem_we   = active && ((job_q != JOB_PROG) || phase);
  assign mem_wd   = (job_q == JOB_PROG) ? (pv_q ? (mem_q & pb_q) : mem_q) : 8'hFF;
  assign rd_data  = mem_q;

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wd;
    mem_q <= mem[mem_addr];
  end

  always_ff @(posedge clk) begin
    if (buf_we) pbuf[buf_addr] <= buf_wdata;
    pb_q <= pbuf[idx[PW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst || buf_clr) pvalid <= '0;
    else if (buf_we)    pvalid[buf_addr] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) pv_q <= 1'b0;
    else     pv_q <= pvalid[idx[PW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      job_q  <= JOB_NONE;
      base_q <= '0;
      idx    <= '0;
      limit  <= '0;
      phase  <= 1'b0;
    end else if (start) begin
      active <= 1'b1;
      job_q  <= job;
      base_q <= base;
      idx    <= '0;
      phase  <= 1'b0;
      case (job)
        JOB_PROG:   limit <= AW'(PAGE_BYTES - 1);
        JOB_SERASE: limit <= AW'(SECTOR_BYTES - 1);
        default:    limit <= AW'(MEM_BYTES - 1);
      endcase
    end else if (active) begin
      if (job_q == JOB_PROG) phase <= !phase;
      if ((job_q != JOB_PROG) || phase) begin
        if (idx == limit) active <= 1'b0;
        else              idx    <= idx + 1'b1;
      end
    end
  end

  AST_START_IDLE: assert property (@(posedge clk) disable iff (rst)
    start |-> !active); // R9
  AST_WALK_BOUND: assert property (@(posedge clk) disable iff (rst)
    active |-> (idx <= limit)); // R5
endmodule

// File: rtl/sfe_cmd_ctrl.sv
module sfe_cmd_ctrl
  import sfe_pkg::*;
#(
  parameter int AW           = 11,
  parameter int PW           = 8,
  parameter int SECTOR_BYTES = 1024,
  parameter int PAGE_BYTES   = 256,
  parameter int T_PROG       = 600,
  parameter int T_SERASE     = 1200,
  parameter int T_BERASE     = 2400,
  localparam int T_MAX = (T_PROG > T_SERASE) ? ((T_PROG > T_BERASE) ? T_PROG : T_BERASE)
                                             : ((T_SERASE > T_BERASE) ? T_SERASE : T_BERASE),
  localparam int TW = $clog2(T_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_rise,
  input  logic          on_boundary,
  input  logic          byte_done,
  input  logic [7:0]    rx_byte,
  input  logic [2:0]    byte_cnt,
  input  logic          eng_active,
  input  logic [7:0]    rd_data,
  output logic [7:0]    tx_byte,
  output logic          start,
  output job_e          job,
  output logic [AW-1:0] base,
  output logic          buf_clr,
  output logic          buf_we,
  output logic [PW-1:0] buf_addr,
  output logic [7:0]    buf_wdata,
  output logic [AW-1:0] rd_addr
);
  localparam logic [AW-1:0] SEC_MASK  = ~AW'(SECTOR_BYTES - 1);
  localparam logic [AW-1:0] PAGE_MASK = ~AW'(PAGE_BYTES - 1);

  logic [7:0]    op_q;
  logic [AW-1:0] addr_q, rd_ptr;
  logic [PW-1:0] pg_off;
  logic          wel, wip, sleep, ok_q;
  logic [TW-1:0] tmr;
  logic          exec, idle_ok, wren_go, sleep_go, wake_go, prog_go, se_go, be_go;

  assign exec     = cs_rise && on_boundary;
  assign idle_ok  = exec && !sleep && !wip;
  assign wren_go  = idle_ok && (op_q == OP_WREN)   && (byte_cnt == 3'd1);
  assign sleep_go = idle_ok && (op_q == OP_SLEEP)  && (byte_cnt == 3'd1);
  assign wake_go  = exec && sleep && (op_q == OP_WAKE) && (byte_cnt != 3'd0);
  assign prog_go  = idle_ok && wel && ok_q && (op_q == OP_PROG) && (byte_cnt == 3'd5);
  assign se_go    = idle_ok && wel && (op_q == OP_SERASE) && (byte_cnt == 3'd4);
  assign be_go    = idle_ok && wel && (op_q == OP_BERASE) && (byte_cnt == 3'd1);

  assign start = prog_go || se_go || be_go;
  always_comb begin
    job  = JOB_NONE;
    base = '0;
    if (prog_go) begin
      job  = JOB_PROG;
      base = addr_q & PAGE_MASK;
    end else if (se_go) begin
      job  = JOB_SERASE;
      base = addr_q & SEC_MASK;
    end else if (be_go) begin
      job  = JOB_BERASE;
    end
  end

  assign buf_clr   = byte_done && (byte_cnt == 3'd1) && (rx_byte == OP_PROG) && !wip && !sleep;
  assign buf_we    = byte_done && (byte_cnt == 3'd5) && (op_q == OP_PROG) && ok_q && !wip;
  assign buf_addr  = pg_off;
  assign buf_wdata = rx_byte;
  assign rd_addr   = rd_ptr;

  always_comb begin
    if (sleep)                                           tx_byte = 8'h00;
    else if (op_q == OP_RDSR)                            tx_byte = {6'b0, wel, wip};
    else if ((op_q == OP_READ) && !wip && (byte_cnt >= 3'd4)) tx_byte = rd_data;
    else                                                 tx_byte = 8'h00;
  end

  // frame decode
  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= '0;
      addr_q <= '0;
      rd_ptr <= '0;
      pg_off <= '0;
      ok_q   <= 1'b0;
    end else if (byte_done) begin
      case (byte_cnt)
        3'd1: begin
          op_q <= rx_byte;
          ok_q <= !wip && !sleep;
        end
        3'd2, 3'd3: addr_q <= AW'({addr_q, rx_byte});
        3'd4: begin
          addr_q <= AW'({addr_q, rx_byte});
          rd_ptr <= AW'({addr_q, rx_byte});
          pg_off <= rx_byte[PW-1:0];
        end
        default: begin
          if (op_q == OP_READ) rd_ptr <= rd_ptr + 1'b1;
          if (op_q == OP_PROG) pg_off <= pg_off + 1'b1;
        end
      endcase
    end
  end

  // state: latch, busy, sleep
  always_ff @(posedge clk) begin
    if (rst) begin
      wel   <= 1'b0;
      wip   <= 1'b0;
      sleep <= 1'b0;
      tmr   <= '0;
    end else begin
      if (wren_go)  wel   <= 1'b1;
      if (sleep_go) sleep <= 1'b1;
      if (wake_go)  sleep <= 1'b0;
      if (start) begin
        wip <= 1'b1;
        if (prog_go)    tmr <= TW'(T_PROG - 1);
        else if (se_go) tmr <= TW'(T_SERASE - 1);
        else            tmr <= TW'(T_BERASE - 1);
      end else if (wip) begin
        if (tmr != '0) tmr <= tmr - 1'b1;
        else if (!eng_active) begin
          wip <= 1'b0;
          wel <= 1'b0;
        end
      end
    end
  end

  AST_START_NEEDS_WEL: assert property (@(posedge clk) disable iff (rst)
    start |-> wel); // R7
  AST_START_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    start |-> (!wip && !sleep)); // R9
  AST_ENGINE_UNDER_WIP: assert property (@(posedge clk) disable iff (rst)
    eng_active |-> wip); // R8
  AST_DONE_CLEARS_WEL: assert property (@(posedge clk) disable iff (rst)
    $fell(wip) |-> !wel); // R8
  AST_SLEEP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (sleep && !cs_rise) |=> sleep); // R10
endmodule

// File: rtl/spi_flash_emu.sv
module spi_flash_emu
  import sfe_pkg::*;
#(
  parameter int MEM_BYTES    = 2048,
  parameter int SECTOR_BYTES = 1024,
  parameter int PAGE_BYTES   = 256,
  parameter int T_PROG       = 600,
  parameter int T_SERASE     = 1200,
  parameter int T_BERASE     = 2400,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  output logic miso
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);

  logic          cs_rise, on_boundary, byte_done;
  logic [7:0]    rx_byte, tx_byte, rd_data, buf_wdata;
  logic [2:0]    byte_cnt;
  logic          start, eng_active, buf_clr, buf_we;
  job_e          job;
  logic [AW-1:0] base, rd_addr;
  logic [PW-1:0] buf_addr;

  sfe_spi_port #(.SYNC_STAGES(SYNC_STAGES)) u_port (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .tx_byte(tx_byte), .cs_rise(cs_rise), .on_boundary(on_boundary),
    .byte_done(byte_done), .rx_byte(rx_byte), .byte_cnt(byte_cnt), .miso(miso)
  );

  sfe_cmd_ctrl #(
    .AW(AW), .PW(PW), .SECTOR_BYTES(SECTOR_BYTES), .PAGE_BYTES(PAGE_BYTES),
    .T_PROG(T_PROG), .T_SERASE(T_SERASE), .T_BERASE(T_BERASE)
  ) u_ctrl (
    .clk(clk), .rst(rst), .cs_rise(cs_rise), .on_boundary(on_boundary),
    .byte_done(byte_done), .rx_byte(rx_byte), .byte_cnt(byte_cnt),
    .eng_active(eng_active), .rd_data(rd_data), .tx_byte(tx_byte),
    .start(start), .job(job), .base(base), .buf_clr(buf_clr), .buf_we(buf_we),
    .buf_addr(buf_addr), .buf_wdata(buf_wdata), .rd_addr(rd_addr)
  );

  sfe_array_engine #(
    .MEM_BYTES(MEM_BYTES), .SECTOR_BYTES(SECTOR_BYTES), .PAGE_BYTES(PAGE_BYTES)
  ) u_engine (
    .clk(clk), .rst(rst), .start(start), .job(job), .base(base),
    .active(eng_active), .buf_clr(buf_clr), .buf_we(buf_we),
    .buf_addr(buf_addr), .buf_wdata(buf_wdata), .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: tb/spi_flash_emu_test.sv
module spi_flash_emu_test;
  localparam int H = 8;
  localparam int NTBL = 12;
  // entry: address, expected byte, requirement number
  localparam logic [35:0] TBL [NTBL] = '{
    {24'h0003FC, 8'h11, 4'd4}, {24'h0003FD, 8'h02, 4'd4},
    {24'h0003FE, 8'h33, 4'd4}, {24'h0003FF, 8'h44, 4'd4},
    {24'h000300, 8'h55, 4'd4}, {24'h000301, 8'h66, 4'd4},
    {24'h000302, 8'hFF, 4'd4}, {24'h000400, 8'hFF, 4'd4},
    {24'h0007FF, 8'hC3, 4'd4}, {24'h000000, 8'h3C, 4'd4},
    {24'h000800, 8'h3C, 4'd12}, {24'h000001, 8'hFF, 4'd6}
  };

  logic clk = 1'b0, rst = 1'b1, cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = !clk;

  spi_flash_emu uut (.clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int b = 7; b >= 0; b--) begin
      mosi = tx[b];
      repeat (H) @(negedge clk);
      rx[b] = miso;
      sck = 1'b1;
      repeat (H) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic sel();
    @(negedge clk);
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic desel();
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (4 * H) @(negedge clk);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] r;
    sel(); xfer(op, r); desel();
  endtask

  task automatic cmd_addr(input logic [7:0] op, input logic [23:0] a, input int n,
                          input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
    logic [7:0] r;
    sel();
    xfer(op, r); xfer(a[23:16], r); xfer(a[15:8], r); xfer(a[7:0], r);
    if (n > 0) xfer(d0, r);
    if (n > 1) xfer(d1, r);
    if (n > 2) xfer(d2, r);
    desel();
  endtask

  task automatic rd_status(output logic [7:0] s);
    logic [7:0] r;
    sel(); xfer(8'h05, r); xfer(8'h00, s); desel();
  endtask

  task automatic rd_byte(input logic [23:0] a, output logic [7:0] d);
    logic [7:0] r;
    sel();
    xfer(8'h03, r); xfer(a[23:16], r); xfer(a[15:8], r); xfer(a[7:0], r);
    xfer(8'h00, d);
    desel();
  endtask

  task automatic wait_idle(input string req);
    logic [7:0] r, s;
    bit idle = 1'b0;
    sel();
    xfer(8'h05, r);
    for (int k = 0; k < 100 && !idle; k++) begin
      xfer(8'h00, s);
      if (!s[0]) idle = 1'b1;
    end
    desel();
    check(req, {7'b0, idle}, 8'h01);
  endtask

  task automatic prog(input logic [23:0] a, input int n,
                      input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
    cmd1(8'h06);
    cmd_addr(8'h02, a, n, d0, d1, d2);
    wait_idle("R8 program completes");
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end

  initial begin
    logic [7:0] v, s, r;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);

    // R1 reset state
    check("R1 idle miso", {7'b0, miso}, 8'h00);
    rd_status(s);
    check("R1 status after reset", s, 8'h00);

    // R7 program without latch
    cmd_addr(8'h02, 24'h000010, 1, 8'hA5, 8'h00, 8'h00);
    rd_status(s);
    check("R7 no busy without latch", s, 8'h00);
    rd_byte(24'h000010, v);
    check("R7 byte untouched", v, 8'hFF);

    // R3 / R2 latch and repeated status
    cmd1(8'h06);
    sel(); xfer(8'h05, r); xfer(8'h00, s); xfer(8'h00, v); desel();
    check("R3 latch set", s, 8'h02);
    check("R2 status repeats", v, 8'h02);

    // R4 page wrap, R8 busy visible
    cmd_addr(8'h02, 24'h0000FE, 3, 8'h12, 8'h34, 8'h56);
    rd_status(s);
    check("R8 busy and latch during program", s, 8'h03);
    wait_idle("R8 busy clears");
    rd_status(s);
    check("R8 latch cleared at end", s, 8'h00);
    rd_byte(24'h0000FE, v); check("R4 first byte", v, 8'h12);
    rd_byte(24'h0000FF, v); check("R4 page end", v, 8'h34);
    rd_byte(24'h000000, v); check("R4 wrap in page", v, 8'h56);

    // R4 AND semantics
    prog(24'h0000FE, 1, 8'hF0, 8'h00, 8'h00);
    rd_byte(24'h0000FE, v); check("R4 only clears bits", v, 8'h10);

    // R5 sector erase, R9 read ignored while busy
    prog(24'h000400, 1, 8'h00, 8'h00, 8'h00);
    cmd1(8'h06);
    cmd_addr(8'hD8, 24'h000005, 0, 8'h00, 8'h00, 8'h00);
    rd_byte(24'h0007F0, v);
    check("R9 read ignored while busy", v, 8'h00);
    wait_idle("R8 erase completes");
    rd_byte(24'h0000FE, v); check("R5 sector erased", v, 8'hFF);
    rd_byte(24'h000000, v); check("R5 sector start erased", v, 8'hFF);
    rd_byte(24'h000400, v); check("R5 other sector kept", v, 8'h00);

    // R11 partial byte and overlong erase frame
    sel(); xfer(8'h06, r);
    for (int b = 0; b < 3; b++) begin
      mosi = 1'b1; repeat (H) @(negedge clk); sck = 1'b1;
      repeat (H) @(negedge clk); sck = 1'b0;
    end
    desel();
    rd_status(s);
    check("R11 partial frame dropped", s, 8'h00);
    cmd1(8'h06);
    cmd_addr(8'hD8, 24'h000400, 1, 8'h00, 8'h00, 8'h00);
    rd_status(s);
    check("R11 long erase frame dropped", s, 8'h02);
    rd_byte(24'h000400, v); check("R11 sector intact", v, 8'h00);

    // R6 bulk erase; R9 sleep opcode ignored while busy
    cmd1(8'hC7);
    cmd1(8'hB9);
    wait_idle("R8 bulk erase completes");
    cmd1(8'h06);
    rd_status(s);
    check("R9 sleep ignored while busy", s, 8'h02);
    rd_byte(24'h000400, v); check("R6 array erased", v, 8'hFF);

    // table set-up (latch already set)
    cmd_addr(8'h02, 24'h0003FC, 3, 8'h11, 8'h22, 8'h33);
    wait_idle("R8 program completes");
    prog(24'h0003FF, 3, 8'h44, 8'h55, 8'h66);
    prog(24'h0007FF, 1, 8'hC3, 8'h00, 8'h00);
    prog(24'h000000, 1, 8'h3C, 8'h00, 8'h00);
    prog(24'h0003FD, 1, 8'h0F, 8'h00, 8'h00);
    for (int i = 0; i < NTBL; i++) begin
      rd_byte(TBL[i][35:12], v);
      check($sformatf("R%0d table entry %0d", TBL[i][3:0], i), v, TBL[i][11:4]);
    end

    // R12 streaming read across array end
    sel();
    xfer(8'h03, r); xfer(8'h00, r); xfer(8'h07, r); xfer(8'hFF, r);
    xfer(8'h00, v); xfer(8'h00, s);
    desel();
    check("R12 stream first", v, 8'hC3);
    check("R12 stream wraps", s, 8'h3C);

    // R10 sleep
    cmd1(8'hB9);
    rd_status(s);
    check("R10 status silent in sleep", s, 8'h00);
    rd_byte(24'h000000, v);
    check("R10 read silent in sleep", v, 8'h00);
    cmd1(8'h06);
    cmd1(8'hAB);
    rd_status(s);
    check("R10 latch not set in sleep", s, 8'h00);
    rd_byte(24'h000000, v);
    check("R10 awake after release", v, 8'h3C);
    cmd1(8'h06);
    rd_status(s);
    check("R10 latch works after release", s, 8'h02);

    finished = 1'b1;
    report();
  end
endmodule